// File: doc/BRIEF.md
# Conversion Result Window Monitor

The monitor watches a stream of converter results, each tagged with the channel it came from, and tests every result it is told to watch against a programmable low and high threshold. One of four window tests is chosen at run time. A match must repeat on a programmable number of consecutive watched results before it counts as an event. The event sets a flag that stays set until software-side logic clears it.

Either one selected channel or every channel is watched. A second output tells the result store whether to keep conversions. In the flag-only type, every conversion is kept. In the start-condition type, nothing is kept until the first filtered event. After that event, everything is kept until an explicit compare-reset command.

Top module: `conv_window_monitor`

## Requirements
- R1: After reset, `hit_flag` is 0 and the storage gate is closed, so `store_en` is 1 when `start_gate` is 0 and 0 when `start_gate` is 1.
- R2: With `win_mode` = 0, a watched result matches only when it is strictly less than `thr_low`.
- R3: With `win_mode` = 1, a watched result matches only when it is strictly greater than `thr_high`.
- R4: With `win_mode` = 2, a result matches when `thr_low` <= result <= `thr_high`. With `win_mode` = 3, a result matches exactly when the mode 2 test fails.
- R5: The event fires on the (`filt_len` + 1)-th consecutive matching watched result. `filt_len` = 0 fires on the first match, and `filt_len` = 3 fires on the fourth.
- R6: A watched result that does not match restarts the consecutive count from zero.
- R7: Results that are not watched leave the consecutive count unchanged and never set the flag.
- R8: With `all_chan` = 1, results from every channel are watched and `sel_chan` has no effect. With `all_chan` = 0, only results whose `res_chan` equals `sel_chan` are watched.
- R9: `hit_flag` stays set until a `flag_clr` pulse clears it. If an event and `flag_clr` arrive in the same cycle, the event wins.
- R10: With `start_gate` = 0 (flag-only type), `store_en` is 1 at all times.
- R11: With `start_gate` = 1 (start-condition type), `store_en` is 0 until a filtered event. It then stays 1, even across later non-matching results, until compare-reset.
- R12: A `cmp_rst` pulse closes the storage gate and zeroes the consecutive count. A result arriving in the same cycle is discarded. `hit_flag` is left unchanged.
- R13: `hit_flag` and `store_en` take their new values at the clock edge that samples the result causing the event, one cycle after the result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_data | input | DATA_W | Conversion result, unsigned |
| res_chan | input | CHAN_W | Channel that produced the result |
| thr_low | input | DATA_W | Lower window threshold |
| thr_high | input | DATA_W | Upper window threshold |
| win_mode | input | 2 | 0 below, 1 above, 2 inside, 3 outside |
| filt_len | input | FILT_W | Extra consecutive matches required before an event |
| all_chan | input | 1 | Watch every channel |
| sel_chan | input | CHAN_W | Channel watched when `all_chan` is 0 |
| start_gate | input | 1 | 0 flag-only type, 1 start-condition type |
| flag_clr | input | 1 | Clears the sticky event flag |
| cmp_rst | input | 1 | Closes the storage gate and zeroes the count |
| hit_flag | output | 1 | Sticky compare-event flag |
| store_en | output | 1 | Conversions presented now are to be stored |

## Verification
The bench builds the monitor with its default parameters: 12-bit results, 4-bit channel numbers and a 2-bit filter length. With a 2-bit filter length, both ends of the filter range are reachable in a few cycles: an event on the first match and an event on the fourth. With 4-bit channel numbers, results from unwatched channels can be interleaved with watched ones, and channel 15 can be exercised under all-channel watching. The thresholds sit at 100 and 200, so results exactly on each threshold test whether the below/above tests are strict and the inside test is inclusive.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

  typedef enum logic [1:0] {
    WIN_BELOW   = 2'd0,
    WIN_ABOVE   = 2'd1,
    WIN_INSIDE  = 2'd2,
    WIN_OUTSIDE = 2'd3
  } win_mode_e;

endpackage

// File: rtl/cwm_window_match.sv
module cwm_window_match
  import cwm_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CHAN_W = 4
) (
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic [DATA_W-1:0] thr_low,
  input  logic [DATA_W-1:0] thr_high,
  input  logic [1:0]        win_mode,
  input  logic              all_chan,
  input  logic [CHAN_W-1:0] sel_chan,
  output logic              cmp_take,
  output logic              cmp_hit
);

  logic is_below;
  logic is_above;
  logic is_inside;

  always_comb begin
    is_below  = (res_data < thr_low);
    is_above  = (res_data > thr_high);
    is_inside = !is_below && !is_above;
    unique case (win_mode_e'(win_mode))
      WIN_BELOW:   cmp_hit = is_below;
      WIN_ABOVE:   cmp_hit = is_above;
      WIN_INSIDE:  cmp_hit = is_inside;
      WIN_OUTSIDE: cmp_hit = !is_inside;
      default:     cmp_hit = 1'b0;
    endcase
    cmp_take = res_valid && (all_chan || (res_chan == sel_chan));
  end

endmodule

// File: rtl/cwm_event_filter.sv
module cwm_event_filter #(
  parameter int FILT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_take,
  input  logic              cmp_hit,
  input  logic              cmp_rst,
  input  logic [FILT_W-1:0] filt_len,
  output logic              evt
);

  logic [FILT_W-1:0] run_q;
  logic [FILT_W-1:0] run_d;
  logic              run_en;

  always_comb begin
    run_d  = run_q;
    evt    = 1'b0;
    run_en = cmp_rst || cmp_take;
    if (cmp_rst) begin
      run_d = '0;
    end else if (cmp_take) begin
      if (!cmp_hit) begin
        run_d = '0;
      end else if (run_q >= filt_len) begin
        evt = 1'b1;
      end else begin
        run_d = run_q + FILT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  p_miss_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_take && !cmp_hit && !cmp_rst) |=> (run_q == '0));

  p_skip_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_take && !cmp_rst) |=> $stable(run_q));

  p_rst_zeroes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_rst |=> (run_q == '0));

endmodule

// File: rtl/cwm_flag_ctrl.sv
module cwm_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic flag_clr,
  input  logic cmp_rst,
  input  logic start_gate,
  output logic hit_flag,
  output logic gate_open
);

  logic flag_q, flag_d;
  logic gate_q, gate_d;
  logic flag_en, gate_en;

  always_comb begin
    flag_en = evt || flag_clr;
    flag_d  = evt ? 1'b1 : 1'b0;
    gate_en = cmp_rst || (evt && start_gate);
    gate_d  = cmp_rst ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else if (gate_en) begin
      gate_q <= gate_d;
    end
  end

  assign hit_flag  = flag_q;
  assign gate_open = gate_q;

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flag && !flag_clr) |=> hit_flag);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !evt) |=> !hit_flag);

  p_gate_closes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_rst |=> !gate_open);

  p_gate_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && !cmp_rst) |=> gate_open);

  p_gate_needs_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_open) |-> hit_flag);

endmodule

// File: rtl/conv_window_monitor.sv
module conv_window_monitor #(
  parameter int DATA_W      = 12,
  parameter int CHAN_W      = 4,
  parameter int FILT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic [DATA_W-1:0] thr_low,
  input  logic [DATA_W-1:0] thr_high,
  input  logic [1:0]        win_mode,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              all_chan,
  input  logic [CHAN_W-1:0] sel_chan,
  input  logic              start_gate,
  input  logic              flag_clr,
  input  logic              cmp_rst,
  output logic              hit_flag,
  output logic              store_en
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_pipe;
  logic              core_rst_n;
  logic              cmp_take;
  logic              cmp_hit;
  logic              evt;
  logic              gate_open;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_pipe <= '0;
        end else begin
          rst_pipe <= {rst_pipe[SYNC_MSB-1:0], 1'b1};
        end
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_pipe <= '0;
        end else begin
          rst_pipe <= 1'b1;
        end
      end
    end
  endgenerate

  assign core_rst_n = rst_pipe[SYNC_MSB];

  cwm_window_match #(
    .DATA_W (DATA_W),
    .CHAN_W (CHAN_W)
  ) u_match (
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_chan  (res_chan),
    .thr_low   (thr_low),
    .thr_high  (thr_high),
    .win_mode  (win_mode),
    .all_chan  (all_chan),
    .sel_chan  (sel_chan),
    .cmp_take  (cmp_take),
    .cmp_hit   (cmp_hit)
  );

  cwm_event_filter #(
    .FILT_W (FILT_W)
  ) u_filter (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .cmp_take (cmp_take),
    .cmp_hit  (cmp_hit),
    .cmp_rst  (cmp_rst),
    .filt_len (filt_len),
    .evt      (evt)
  );

  cwm_flag_ctrl u_flags (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .evt        (evt),
    .flag_clr   (flag_clr),
    .cmp_rst    (cmp_rst),
    .start_gate (start_gate),
    .hit_flag   (hit_flag),
    .gate_open  (gate_open)
  );

  assign store_en = !start_gate || gate_open;

  p_flag_after_result_r13: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(hit_flag) |-> $past(res_valid));

  p_unwatched_quiet_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!hit_flag && !cmp_take) |=> !hit_flag);

endmodule

// File: tb/conv_window_monitor_bench.sv
`timescale 1ns/1ps
module conv_window_monitor_bench;

  typedef struct packed {
    logic        clr;
    logic [1:0]  mode;
    logic [1:0]  filt;
    logic        all;
    logic [3:0]  sel;
    logic [3:0]  chan;
    logic [11:0] data;
    logic        exp;
  } vec_t;

  localparam int NVEC = 25;

  // thresholds fixed at 100 / 200 while walking the table
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 2'd0, 1'b0, 4'd3, 4'd3, 12'd99,  1'b1}, // R2 below
    '{1'b1, 2'd0, 2'd0, 1'b0, 4'd3, 4'd3, 12'd100, 1'b0}, // R2 on low threshold
    '{1'b0, 2'd1, 2'd0, 1'b0, 4'd3, 4'd3, 12'd200, 1'b0}, // R3 on high threshold
    '{1'b0, 2'd1, 2'd0, 1'b0, 4'd3, 4'd3, 12'd201, 1'b1}, // R3 above
    '{1'b1, 2'd2, 2'd0, 1'b0, 4'd3, 4'd3, 12'd100, 1'b1}, // R4 inclusive, R9 set wins
    '{1'b1, 2'd2, 2'd0, 1'b0, 4'd3, 4'd3, 12'd201, 1'b0}, // R4 outside fails inside
    '{1'b0, 2'd3, 2'd0, 1'b0, 4'd3, 4'd3, 12'd150, 1'b0}, // R4 inside fails outside
    '{1'b0, 2'd3, 2'd0, 1'b0, 4'd3, 4'd3, 12'd99,  1'b1}, // R4 outside
    '{1'b1, 2'd2, 2'd2, 1'b0, 4'd3, 4'd3, 12'd150, 1'b0}, // R5 first of three
    '{1'b0, 2'd2, 2'd2, 1'b0, 4'd3, 4'd3, 12'd160, 1'b0}, // R5 second
    '{1'b0, 2'd2, 2'd2, 1'b0, 4'd3, 4'd3, 12'd170, 1'b1}, // R5 third fires
    '{1'b1, 2'd2, 2'd2, 1'b0, 4'd3, 4'd3, 12'd50,  1'b0}, // R6 miss
    '{1'b0, 2'd2, 2'd2, 1'b0, 4'd3, 4'd3, 12'd150, 1'b0}, // R6 run 1
    '{1'b0, 2'd2, 2'd2, 1'b0, 4'd3, 4'd3, 12'd10,  1'b0}, // R6 miss restarts
    '{1'b0, 2'd2, 2'd2, 1'b0, 4'd3, 4'd3, 12'd150, 1'b0}, // R6 run 1
    '{1'b0, 2'd2, 2'd2, 1'b0, 4'd3, 4'd5, 12'd10,  1'b0}, // R7 unwatched miss
    '{1'b0, 2'd2, 2'd2, 1'b0, 4'd3, 4'd3, 12'd150, 1'b0}, // R7 run 2
    '{1'b0, 2'd2, 2'd2, 1'b0, 4'd3, 4'd3, 12'd150, 1'b1}, // R7 run 3 fires
    '{1'b1, 2'd2, 2'd0, 1'b0, 4'd3, 4'd7, 12'd150, 1'b0}, // R7 unwatched match
    '{1'b0, 2'd2, 2'd0, 1'b1, 4'd3, 4'd7, 12'd150, 1'b1}, // R8 all channels
    '{1'b1, 2'd0, 2'd3, 1'b1, 4'd3, 4'd9, 12'd150, 1'b0}, // R8 watched miss
    '{1'b0, 2'd0, 2'd3, 1'b1, 4'd3, 4'd0, 12'd5,   1'b0}, // R5 filter 3, run 1
    '{1'b0, 2'd0, 2'd3, 1'b1, 4'd3, 4'd15, 12'd5,  1'b0}, // R8 channel 15, run 2
    '{1'b0, 2'd0, 2'd3, 1'b1, 4'd3, 4'd3, 12'd5,   1'b0}, // R5 run 3
    '{1'b0, 2'd0, 2'd3, 1'b1, 4'd3, 4'd8, 12'd5,   1'b1}  // R5 fourth fires
  };

  logic        clk;
  logic        rst_n;
  logic        res_valid;
  logic [11:0] res_data;
  logic [3:0]  res_chan;
  logic [11:0] thr_low;
  logic [11:0] thr_high;
  logic [1:0]  win_mode;
  logic [1:0]  filt_len;
  logic        all_chan;
  logic [3:0]  sel_chan;
  logic        start_gate;
  logic        flag_clr;
  logic        cmp_rst;
  logic        hit_flag;
  logic        store_en;

  int checks = 0;
  int errors = 0;

  conv_window_monitor #(
    .DATA_W      (12),
    .CHAN_W      (4),
    .FILT_W      (2),
    .SYNC_STAGES (2)
  ) u_conv_window_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_chan   (res_chan),
    .thr_low    (thr_low),
    .thr_high   (thr_high),
    .win_mode   (win_mode),
    .filt_len   (filt_len),
    .all_chan   (all_chan),
    .sel_chan   (sel_chan),
    .start_gate (start_gate),
    .flag_clr   (flag_clr),
    .cmp_rst    (cmp_rst),
    .hit_flag   (hit_flag),
    .store_en   (store_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // present one cycle of inputs, then return at the following falling edge
  task automatic cycle(input logic v, input logic [3:0] ch, input logic [11:0] d,
                       input logic clr, input logic rst);
    @(negedge clk);
    res_valid = v;
    res_chan  = ch;
    res_data  = d;
    flag_clr  = clr;
    cmp_rst   = rst;
    @(negedge clk);
    res_valid = 1'b0;
    flag_clr  = 1'b0;
    cmp_rst   = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    res_valid  = 1'b0;
    res_data   = '0;
    res_chan   = '0;
    thr_low    = 12'd100;
    thr_high   = 12'd200;
    win_mode   = 2'd0;
    filt_len   = 2'd0;
    all_chan   = 1'b0;
    sel_chan   = 4'd3;
    start_gate = 1'b0;
    flag_clr   = 1'b0;
    cmp_rst    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 flag after reset", hit_flag, 1'b0);
    check("R1 store_en flag-only type", store_en, 1'b1);
    start_gate = 1'b1;
    #1;
    check("R1 gate closed after reset", store_en, 1'b0);
    start_gate = 1'b0;
    #1;

    // table walk: R2..R9, R10 store_en in flag-only type, R13 one-cycle timing
    for (int i = 0; i < NVEC; i++) begin
      win_mode = VECS[i].mode;
      filt_len = VECS[i].filt;
      all_chan = VECS[i].all;
      sel_chan = VECS[i].sel;
      cycle(1'b1, VECS[i].chan, VECS[i].data, VECS[i].clr, 1'b0);
      check($sformatf("R13 vector %0d flag", i), hit_flag, VECS[i].exp);
      check($sformatf("R10 vector %0d store_en", i), store_en, 1'b1);
    end

    // R11 start-condition type
    start_gate = 1'b1;
    win_mode   = 2'd1;
    filt_len   = 2'd1;
    all_chan   = 1'b0;
    sel_chan   = 4'd2;
    #1;
    check("R11 gate closed before event", store_en, 1'b0);
    cycle(1'b0, 4'd0, 12'd0, 1'b0, 1'b1);
    cycle(1'b0, 4'd0, 12'd0, 1'b1, 1'b0);
    check("R9 flag cleared by pulse", hit_flag, 1'b0);
    cycle(1'b1, 4'd2, 12'd250, 1'b0, 1'b0);
    check("R11 first match keeps gate closed", store_en, 1'b0);
    check("R5 first match of two no flag", hit_flag, 1'b0);
    cycle(1'b1, 4'd2, 12'd250, 1'b0, 1'b0);
    check("R11 gate opens on event", store_en, 1'b1);
    check("R5 second match sets flag", hit_flag, 1'b1);
    cycle(1'b1, 4'd2, 12'd0, 1'b0, 1'b0);
    check("R11 gate stays open after miss", store_en, 1'b1);
    cycle(1'b0, 4'd0, 12'd0, 1'b1, 1'b0);
    check("R9 flag cleared", hit_flag, 1'b0);
    check("R11 gate unaffected by flag clear", store_en, 1'b1);

    // R12 compare-reset
    cycle(1'b1, 4'd2, 12'd250, 1'b0, 1'b0);
    cycle(1'b1, 4'd2, 12'd250, 1'b0, 1'b1);
    check("R12 gate closed by compare-reset", store_en, 1'b0);
    check("R12 same-cycle result discarded", hit_flag, 1'b0);
    cycle(1'b1, 4'd2, 12'd250, 1'b0, 1'b0);
    check("R12 count restarted", hit_flag, 1'b0);
    cycle(1'b1, 4'd2, 12'd250, 1'b0, 1'b0);
    check("R12 event after fresh run", hit_flag, 1'b1);
    check("R12 gate reopened", store_en, 1'b1);
    cycle(1'b0, 4'd0, 12'd0, 1'b0, 1'b1);
    check("R12 compare-reset closes gate", store_en, 1'b0);
    check("R12 compare-reset keeps flag", hit_flag, 1'b1);

    // R10 switching back to flag-only type
    start_gate = 1'b0;
    #1;
    check("R10 flag-only type stores", store_en, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule